// File: doc/BRIEF.md
# Floating-Point Min/Max Unit

This block takes two single-precision binary floating-point operands and returns the smaller or the larger of them. A one-bit select chooses minimum or maximum. A two-bit policy field, given with each operation, chooses one of four semantics. They differ in how quiet NaNs, signaling NaNs and the sign of zero are treated, so one datapath can serve several language and library definitions of min and max.

Each operand is classified as NaN, signaling NaN or zero. It is also mapped to an unsigned ordering key, so that one integer comparison orders every non-NaN value, with -0 below +0. A selection stage applies the chosen policy. The result and an invalid-operation flag are registered. They appear one clock after the operation is presented, with a valid strobe for that cycle.

Top module: `fpmm_unit`

## Requirements
- R1: Policy 2'b00 (NaN-propagating). If exactly one operand is a NaN (exponent field all ones, fraction nonzero), the result is that operand with fraction bit 22 set. If both operands are NaN, the result is 0x7FC00000.
- R2: Policy 2'b01 (number-preferring). If exactly one operand is a NaN, quiet or signaling, the other operand is returned unchanged. If both operands are NaN, the result is 0x7FC00000.
- R3: Under policies 2'b00 and 2'b01, -0 (0x80000000) is ordered strictly below +0 (0x00000000). Minimum of the two zeros gives 0x80000000 and maximum gives 0x00000000, whatever the operand order.
- R4: Policy 2'b10 (legacy). A signaling NaN has fraction bit 22 clear. If exactly one operand is a signaling NaN, the result is that operand with bit 22 set, keeping its sign and the rest of its payload. If both operands are NaN, the result is 0x7FC00000.
- R5: Policy 2'b10. A single quiet NaN operand (bit 22 set) is ignored, and the other operand is returned.
- R6: Policy 2'b10. When the operands compare equal, including +0 against -0, operand A is returned.
- R7: Policy 2'b11 (compare-select). If either operand is a NaN, or the operands compare equal (+0 equals -0), operand B is returned. Otherwise A is returned when A<B for minimum (A>B for maximum), and B is returned otherwise.
- R8: For two non-NaN operands that are not equal, every policy returns the numerically smaller one for minimum (select 0) and the larger one for maximum (select 1). This includes negative values, subnormals and infinities.
- R9: The invalid flag is 1 for an operation in which either operand is a signaling NaN, under every policy, and 0 otherwise.
- R10: The result, the invalid flag and valid_out appear on the first rising edge after valid_in is sampled high. valid_out is high for exactly that cycle. When valid_in is low, the result and the flag hold their previous values.
- R11: An active-low reset clears valid_out at once. While reset is held, no valid_out is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_in | input | 1 | Operation present on the inputs this cycle |
| op_a | input | 32 | Operand A, single-precision |
| op_b | input | 32 | Operand B, single-precision |
| sel_max | input | 1 | 0 selects minimum, 1 selects maximum |
| mode | input | 2 | Policy: 00 NaN-propagating, 01 number-preferring, 10 legacy, 11 compare-select |
| valid_out | output | 1 | Result valid, one cycle after valid_in |
| result | output | 32 | Selected value |
| invalid | output | 1 | Invalid-operation flag (a signaling NaN was seen) |

## Verification
The hardest corners are NaN operands whose payload and sign must survive quieting. Another is the pair +0/-0, which compares equal but orders as unequal depending on the policy. Every policy gives these corners a different answer, and they occur only with hand-chosen bit patterns. The stimulus sweeps every ordered pair from a value set that holds both signs of zero, both infinities, subnormals, a quiet NaN and signaling NaNs of each sign. It runs this set across all four policies and both selections, and compares each result with a reference model written from the requirements. Directed cases then pin the exact quieted payloads and the equal-zero choices.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;
  localparam int DEF_DATA_W = 32;
  localparam int DEF_EXP_W  = 8;

  typedef enum logic [1:0] {
    POL_PROPAGATE = 2'b00,
    POL_NUMBER    = 2'b01,
    POL_LEGACY    = 2'b10,
    POL_CMPSEL    = 2'b11
  } fpmm_policy_e;
endpackage

// File: rtl/fpmm_classify.sv
module fpmm_classify #(
  parameter int DATA_W = 32,
  parameter int EXP_W  = 8
) (
  input  logic [DATA_W-1:0] opnd,
  output logic              is_nan,
  output logic              is_snan,
  output logic              is_zero,
  output logic [DATA_W-1:0] key,
  output logic [DATA_W-1:0] quieted
);
  localparam int FRAC_W = DATA_W - 1 - EXP_W;
  localparam int QBIT   = FRAC_W - 1;

  logic exp_all_ones;
  logic frac_nonzero;

  always_comb begin
    exp_all_ones = &opnd[DATA_W-2 -: EXP_W];
    frac_nonzero = |opnd[FRAC_W-1:0];
    is_nan       = exp_all_ones & frac_nonzero;
    is_snan      = is_nan & ~opnd[QBIT];
    is_zero      = ~|opnd[DATA_W-2:0];
    // order-preserving unsigned key: negatives inverted, positives lifted
    key          = opnd[DATA_W-1] ? ~opnd : {1'b1, opnd[DATA_W-2:0]};
    quieted      = opnd;
    quieted[QBIT] = 1'b1;
  end
endmodule

// File: rtl/fpmm_order.sv
module fpmm_order #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] key_a,
  input  logic [DATA_W-1:0] key_b,
  input  logic              zero_a,
  input  logic              zero_b,
  output logic              a_lt_b,
  output logic              a_gt_b,
  output logic              ieee_eq
);
  always_comb begin
    a_lt_b  = key_a < key_b;
    a_gt_b  = key_a > key_b;
    ieee_eq = (key_a == key_b) | (zero_a & zero_b);
  end
endmodule

// File: rtl/fpmm_pick.sv
module fpmm_pick
  import fpmm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EXP_W  = 8
) (
  input  fpmm_policy_e      policy,
  input  logic              sel_max,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [DATA_W-1:0] quiet_a,
  input  logic [DATA_W-1:0] quiet_b,
  input  logic              nan_a,
  input  logic              nan_b,
  input  logic              snan_a,
  input  logic              snan_b,
  input  logic              a_lt_b,
  input  logic              a_gt_b,
  input  logic              ieee_eq,
  output logic [DATA_W-1:0] picked
);
  localparam int FRAC_W = DATA_W - 1 - EXP_W;
  localparam logic [DATA_W-1:0] CANON_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic              take_a;
  logic [DATA_W-1:0] ordered;
  logic              both_nan;

  always_comb begin
    take_a   = sel_max ? a_gt_b : a_lt_b;
    ordered  = take_a ? op_a : op_b;
    both_nan = nan_a & nan_b;
    picked   = ordered;
    unique case (policy)
      POL_PROPAGATE: begin
        if (both_nan)   picked = CANON_NAN;
        else if (nan_a) picked = quiet_a;
        else if (nan_b) picked = quiet_b;
      end
      POL_NUMBER: begin
        if (both_nan)   picked = CANON_NAN;
        else if (nan_a) picked = op_b;
        else if (nan_b) picked = op_a;
      end
      POL_LEGACY: begin
        if (both_nan)     picked = CANON_NAN;
        else if (snan_a)  picked = quiet_a;
        else if (snan_b)  picked = quiet_b;
        else if (nan_a)   picked = op_b;
        else if (nan_b)   picked = op_a;
        else if (ieee_eq) picked = op_a;
      end
      POL_CMPSEL: begin
        if (nan_a | nan_b | ieee_eq) picked = op_b;
      end
      default: picked = ordered;
    endcase
  end
endmodule

// File: rtl/fpmm_unit.sv
module fpmm_unit
  import fpmm_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int EXP_W  = DEF_EXP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_in,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              sel_max,
  input  logic [1:0]        mode,
  output logic              valid_out,
  output logic [DATA_W-1:0] result,
  output logic              invalid
);
  localparam int FRAC_W = DATA_W - 1 - EXP_W;
  localparam int N_OPS  = 2;

  logic [DATA_W-1:0] opnd    [N_OPS];
  logic [DATA_W-1:0] key     [N_OPS];
  logic [DATA_W-1:0] quieted [N_OPS];
  logic [N_OPS-1:0]  is_nan;
  logic [N_OPS-1:0]  is_snan;
  logic [N_OPS-1:0]  is_zero;

  always_comb begin
    opnd[0] = op_a;
    opnd[1] = op_b;
  end

  for (genvar i = 0; i < N_OPS; i++) begin : g_cls
    fpmm_classify #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_cls (
      .opnd    (opnd[i]),
      .is_nan  (is_nan[i]),
      .is_snan (is_snan[i]),
      .is_zero (is_zero[i]),
      .key     (key[i]),
      .quieted (quieted[i])
    );
  end

  logic a_lt_b, a_gt_b, ieee_eq;

  fpmm_order #(.DATA_W(DATA_W)) u_order (
    .key_a   (key[0]),
    .key_b   (key[1]),
    .zero_a  (is_zero[0]),
    .zero_b  (is_zero[1]),
    .a_lt_b  (a_lt_b),
    .a_gt_b  (a_gt_b),
    .ieee_eq (ieee_eq)
  );

  fpmm_policy_e      policy;
  logic [DATA_W-1:0] picked;

  assign policy = fpmm_policy_e'(mode);

  fpmm_pick #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_pick (
    .policy  (policy),
    .sel_max (sel_max),
    .op_a    (op_a),
    .op_b    (op_b),
    .quiet_a (quieted[0]),
    .quiet_b (quieted[1]),
    .nan_a   (is_nan[0]),
    .nan_b   (is_nan[1]),
    .snan_a  (is_snan[0]),
    .snan_b  (is_snan[1]),
    .a_lt_b  (a_lt_b),
    .a_gt_b  (a_gt_b),
    .ieee_eq (ieee_eq),
    .picked  (picked)
  );

  // next-state logic
  logic              valid_d, invalid_d;
  logic [DATA_W-1:0] result_d;
  logic              load_en;

  always_comb begin
    load_en   = valid_in;
    valid_d   = valid_in;
    result_d  = load_en ? picked : result;
    invalid_d = load_en ? (|is_snan) : invalid;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_out <= 1'b0;
      result    <= '0;
      invalid   <= 1'b0;
    end else begin
      valid_out <= valid_d;
      result    <= result_d;
      invalid   <= invalid_d;
    end
  end

  // R10
  strobe_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> valid_out);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> (!valid_out && $stable(result) && $stable(invalid)));
  // R9
  snan_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && (is_snan != '0)) |=> invalid);
  // R1
  prop_nan_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && mode == POL_PROPAGATE && (is_nan != '0)) |=>
      ((&result[DATA_W-2 -: EXP_W]) && result[FRAC_W-1]));
  // R2
  number_keeps_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && mode == POL_NUMBER && is_nan[0] && !is_nan[1]) |=>
      (result == $past(op_b)));
endmodule

// File: tb/fpmm_unit_bench.sv
module fpmm_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_in;
  logic [31:0] op_a, op_b;
  logic        sel_max;
  logic [1:0]  mode;
  logic        valid_out;
  logic [31:0] result;
  logic        invalid;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  fpmm_unit u_fpmm_unit (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .op_a(op_a), .op_b(op_b),
    .sel_max(sel_max), .mode(mode), .valid_out(valid_out), .result(result),
    .invalid(invalid)
  );

  localparam logic [31:0] QNAN_C = 32'h7FC00000;

  function automatic logic f_nan(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction
  function automatic logic f_snan(input logic [31:0] x);
    return f_nan(x) && !x[22];
  endfunction
  function automatic logic f_zero(input logic [31:0] x);
    return x[30:0] == 0;
  endfunction
  // strict numeric order with -0 below +0
  function automatic logic f_below(input logic [31:0] a, input logic [31:0] b);
    if (f_zero(a) && f_zero(b)) return a[31] && !b[31];
    if (a[31] != b[31]) return a[31];
    if (!a[31]) return a[30:0] < b[30:0];
    return a[30:0] > b[30:0];
  endfunction
  function automatic logic f_equal(input logic [31:0] a, input logic [31:0] b);
    return (a == b) || (f_zero(a) && f_zero(b));
  endfunction
  function automatic logic [31:0] f_ref(input logic [31:0] a, input logic [31:0] b,
                                        input logic mx, input logic [1:0] md);
    logic na, nb, win;
    na  = f_nan(a);
    nb  = f_nan(b);
    win = mx ? f_below(b, a) : f_below(a, b);
    case (md)
      2'b00: begin
        if (na && nb) return QNAN_C;
        if (na) return a | 32'h0040_0000;
        if (nb) return b | 32'h0040_0000;
        return win ? a : b;
      end
      2'b01: begin
        if (na && nb) return QNAN_C;
        if (na) return b;
        if (nb) return a;
        return win ? a : b;
      end
      2'b10: begin
        if (na && nb) return QNAN_C;
        if (f_snan(a)) return a | 32'h0040_0000;
        if (f_snan(b)) return b | 32'h0040_0000;
        if (na) return b;
        if (nb) return a;
        if (f_equal(a, b)) return a;
        return win ? a : b;
      end
      default: begin
        if (na || nb || f_equal(a, b)) return b;
        return win ? a : b;
      end
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // one operation; returns at the negedge after the capturing edge
  task automatic apply(input logic [31:0] a, input logic [31:0] b,
                       input logic mx, input logic [1:0] md);
    @(negedge clk);
    op_a = a; op_b = b; sel_max = mx; mode = md; valid_in = 1'b1;
    @(negedge clk);
    valid_in = 1'b0;
  endtask

  task automatic op_check(input string tag, input logic [31:0] a, input logic [31:0] b,
                          input logic mx, input logic [1:0] md, input logic [31:0] exp);
    apply(a, b, mx, md);
    check({tag, " result"}, result, exp);
    check("R9 flag", {31'b0, invalid}, {31'b0, f_snan(a) || f_snan(b)});
  endtask

  task automatic t_reset;
    rst_n = 1'b0; valid_in = 1'b0; op_a = 0; op_b = 0; sel_max = 0; mode = 0;
    repeat (3) @(negedge clk);
    check("R11 valid_out in reset", {31'b0, valid_out}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 valid_out after release", {31'b0, valid_out}, 32'd0);
  endtask

  task automatic t_propagate;
    op_check("R1 qnan a", 32'h7FC00001, 32'h3F800000, 1'b0, 2'b00, 32'h7FC00001);
    op_check("R1 snan b", 32'h3F800000, 32'h7F800001, 1'b1, 2'b00, 32'h7FC00001);
    op_check("R1 both nan", 32'hFFC00123, 32'h7F800001, 1'b0, 2'b00, QNAN_C);
  endtask

  task automatic t_number;
    op_check("R2 snan a", 32'hFF800005, 32'h40000000, 1'b0, 2'b01, 32'h40000000);
    op_check("R2 qnan b", 32'hC0000000, 32'h7FC00000, 1'b1, 2'b01, 32'hC0000000);
    op_check("R2 both nan", 32'h7FC00000, 32'hFF800001, 1'b1, 2'b01, QNAN_C);
  endtask

  task automatic t_zeros;
    op_check("R3 prop min +0,-0", 32'h00000000, 32'h80000000, 1'b0, 2'b00, 32'h80000000);
    op_check("R3 prop max -0,+0", 32'h80000000, 32'h00000000, 1'b1, 2'b00, 32'h00000000);
    op_check("R3 num min -0,+0", 32'h80000000, 32'h00000000, 1'b0, 2'b01, 32'h80000000);
    op_check("R3 num max +0,-0", 32'h00000000, 32'h80000000, 1'b1, 2'b01, 32'h00000000);
  endtask

  task automatic t_legacy;
    op_check("R4 snan a", 32'h7F800001, 32'h3F800000, 1'b0, 2'b10, 32'h7FC00001);
    op_check("R4 snan b payload", 32'h3F800000, 32'hFFA00003, 1'b1, 2'b10, 32'hFFE00003);
    op_check("R4 both nan", 32'h7FC00000, 32'h7F800002, 1'b0, 2'b10, QNAN_C);
    op_check("R5 qnan a ignored", 32'h7FC00000, 32'hC0400000, 1'b0, 2'b10, 32'hC0400000);
    op_check("R5 qnan b ignored", 32'h40400000, 32'hFFC00009, 1'b1, 2'b10, 32'h40400000);
    op_check("R6 min +0,-0", 32'h00000000, 32'h80000000, 1'b0, 2'b10, 32'h00000000);
    op_check("R6 max -0,+0", 32'h80000000, 32'h00000000, 1'b1, 2'b10, 32'h80000000);
  endtask

  task automatic t_cmpsel;
    op_check("R7 nan a gives b", 32'h7FC00000, 32'h3F800000, 1'b0, 2'b11, 32'h3F800000);
    op_check("R7 nan b gives b", 32'h3F800000, 32'h7FC00001, 1'b0, 2'b11, 32'h7FC00001);
    op_check("R7 zeros give b", 32'h00000000, 32'h80000000, 1'b0, 2'b11, 32'h80000000);
    op_check("R7 min", 32'h3F800000, 32'h40000000, 1'b0, 2'b11, 32'h3F800000);
    op_check("R7 max", 32'h3F800000, 32'h40000000, 1'b1, 2'b11, 32'h40000000);
  endtask

  task automatic t_sweep;
    logic [31:0] vals [13];
    vals = '{32'h3F800000, 32'hBF800000, 32'h00000001, 32'h80000001,
             32'h7F800000, 32'hFF800000, 32'h40490FDB, 32'hC0490FDB,
             32'h00000000, 32'h80000000, 32'h7FC00001, 32'h7F800001,
             32'hFFA00000};
    for (int md = 0; md < 4; md++)
      for (int mx = 0; mx < 2; mx++)
        for (int i = 0; i < 13; i++)
          for (int j = 0; j < 13; j++) begin
            apply(vals[i], vals[j], mx[0], md[1:0]);
            check("R8 sweep valid", {31'b0, valid_out}, 32'd1);
            check($sformatf("R8 sweep mode%0d %08h %08h", md, vals[i], vals[j]),
                  result, f_ref(vals[i], vals[j], mx[0], md[1:0]));
            check("R9 sweep flag", {31'b0, invalid},
                  {31'b0, f_snan(vals[i]) || f_snan(vals[j])});
          end
  endtask

  task automatic t_timing;
    logic [31:0] held;
    @(negedge clk);
    op_a = 32'h40000000; op_b = 32'h3F800000; sel_max = 1'b0; mode = 2'b01;
    valid_in = 1'b1;
    check("R10 no early valid", {31'b0, valid_out}, 32'd0);
    @(negedge clk);
    valid_in = 1'b0;
    check("R10 valid one cycle later", {31'b0, valid_out}, 32'd1);
    check("R10 result one cycle later", result, 32'h3F800000);
    held = result;
    op_a = 32'h7F800001; op_b = 32'hC0000000;
    @(negedge clk);
    check("R10 valid single cycle", {31'b0, valid_out}, 32'd0);
    @(negedge clk);
    check("R10 result held", result, held);
    check("R10 flag held", {31'b0, invalid}, 32'd0);
    // reset during a pending operation
    op_a = 32'h3F800000; op_b = 32'h40000000; valid_in = 1'b1;
    #5 rst_n = 1'b0;
    @(negedge clk);
    check("R11 reset kills valid", {31'b0, valid_out}, 32'd0);
    valid_in = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    t_reset();
    t_propagate();
    t_number();
    t_zeros();
    t_legacy();
    t_cmpsel();
    t_timing();
    t_sweep();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule